// File: doc/BRIEF.md
# Interrupt Domain Register Decoder

This block sits between a 32-bit memory-mapped access port and the per-source state of an interrupt domain. It takes one access per cycle, works out which register it addresses, and turns writes into single-cycle strobes. Those strobes go to the source bank as per-source set and clear masks for the pending and enable bits, configuration and target write enables with a source index, and a write enable for the message generator. Reads are served from vectors and words that the source bank and message generator present. The reply comes one cycle after the access.

Only whole, aligned 32-bit words are accepted. The domain-wide interrupt-enable flag is the one piece of state held in this block. Several registers do not read back what was written. The clear-pending word array returns the rectified input levels. All by-number registers return zero. A second set-pending-by-number register takes its source number in the opposite byte order.

Top module: `irq_regdec`

## Requirements
- R1: An access with `acc_addr[1:0]` not zero, or with `acc_size` not equal to 4, gets `rsp_err`=1 and `rsp_rdata`=0. It raises no strobe and leaves `domain_ie` unchanged.
- R2: An aligned 4-byte access to an offset outside every region listed in R3 to R9 gets `rsp_err`=1 and raises no strobe. Every access that R3 to R9 accept gets `rsp_err`=0.
- R3: Offset 0x0000 reads 0x80000004 OR (`domain_ie` << 8). A write loads bit 8 of the data into `domain_ie` and ignores every other bit.
- R4: The source configuration array starts at 0x0004 and the target array starts at 0x3004. Offset base+(i-1)*4 selects source i, for i from 1 to NSRC. A write pulses `cfg_we` or `tgt_we` with `sel_src`=i. A read returns `cfg_rdata` or `tgt_rdata` for the `sel_src` this block presents.
- R5: The bit-vector arrays are set-pending at 0x1C00, clear-pending at 0x1D00, set-enable at 0x1E00 and clear-enable at 0x1F00. Each array holds ceil((NSRC+1)/32) words, and bit i of word w stands for source 32*w+i. A write raises the matching mask only for bits written as 1, and never for source 0 or any source above NSRC.
- R6: A word read returns pending bits at 0x1C00, rectified input bits at 0x1D00 and enable bits at 0x1E00, with source 0 and sources above NSRC reading 0. A read at 0x1F00 returns 0.
- R7: The by-number registers are set-pending at 0x1CDC, clear-pending at 0x1DDC, set-enable at 0x1EDC, clear-enable at 0x1FDC, and set-pending at 0x2000. Writing n, with 1 <= n <= NSRC, raises bit n only on the matching mask. Writing 0 or any value above NSRC raises nothing and is not an error. These registers read 0.
- R8: A write to 0x2004 swaps the four bytes of the data (bits 7:0 become 31:24) and then acts as the set-pending-by-number register on the result. It reads 0.
- R9: A write to 0x3000 pulses `gen_we`, with the data on `wr_data`. A read of 0x3000 returns `gen_rdata`.
- R10: `rsp_valid` is high exactly in the cycle after a cycle with `acc_valid` high. Writes return `rsp_rdata`=0. Strobes are high only in the cycle of an accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_addr | input | AW | Byte offset into the register space |
| acc_size | input | 3 | Access length in bytes |
| acc_wdata | input | 32 | Write data |
| pend_bits | input | NSRC+1 | Pending bit per source |
| enab_bits | input | NSRC+1 | Enable bit per source |
| rin_bits | input | NSRC+1 | Rectified input level per source |
| cfg_rdata | input | 32 | Configuration word of source `sel_src` |
| tgt_rdata | input | 32 | Target word of source `sel_src` |
| gen_rdata | input | 32 | Message generator register contents |
| sel_src | output | clog2(NSRC+1) | Source addressed by a configuration or target access |
| cfg_we | output | 1 | Configuration write strobe |
| tgt_we | output | 1 | Target write strobe |
| gen_we | output | 1 | Message generator write strobe |
| wr_data | output | 32 | Data for the write strobes |
| pend_set | output | NSRC+1 | Sources whose pending bit is set |
| pend_clr | output | NSRC+1 | Sources whose pending bit is cleared |
| enab_set | output | NSRC+1 | Sources whose enable bit is set |
| enab_clr | output | NSRC+1 | Sources whose enable bit is cleared |
| domain_ie | output | 1 | Domain interrupt enable |
| rsp_valid | output | 1 | Reply present |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Access rejected |

## Verification
The edges of the source numbering are the hardest to reach. These are source 0 in word 0, the last real source in the final partial word, and the first number past NSRC. Purely random 32-bit data would seldom hit them through the by-number and byte-swapped registers. The stimulus therefore draws by-number values from a small range that straddles 0 and NSRC. It builds the byte-swapped value from such a number, and it picks array indices one entry past each region's end. Directed writes of all-ones words drive every bit of both vector words at once.

// File: rtl/irq_regdec_pkg.sv
package irq_regdec_pkg;

   localparam int unsigned OFS_DOM     = 32'h0000;
   localparam int unsigned OFS_CFG     = 32'h0004;
   localparam int unsigned OFS_SETIP   = 32'h1C00;
   localparam int unsigned OFS_SETIPN  = 32'h1CDC;
   localparam int unsigned OFS_INP     = 32'h1D00;
   localparam int unsigned OFS_CLRIPN  = 32'h1DDC;
   localparam int unsigned OFS_SETIE   = 32'h1E00;
   localparam int unsigned OFS_SETIEN  = 32'h1EDC;
   localparam int unsigned OFS_CLRIE   = 32'h1F00;
   localparam int unsigned OFS_CLRIEN  = 32'h1FDC;
   localparam int unsigned OFS_NUM_LE  = 32'h2000;
   localparam int unsigned OFS_NUM_BE  = 32'h2004;
   localparam int unsigned OFS_GEN     = 32'h3000;
   localparam int unsigned OFS_TGT     = 32'h3004;

   localparam logic [31:0] DOM_FIXED  = 32'h8000_0000;
   localparam int unsigned DOM_DM_BIT = 2;
   localparam int unsigned DOM_IE_BIT = 8;

   typedef enum logic [3:0] {
      RG_NONE, RG_DOM, RG_CFG, RG_TGT,
      RG_SETIP, RG_INP, RG_SETIE, RG_CLRIE,
      RG_SETIPN, RG_CLRIPN, RG_SETIEN, RG_CLRIEN,
      RG_NUM_LE, RG_NUM_BE, RG_GEN
   } region_t;

   function automatic logic [31:0] swap_bytes(input logic [31:0] v);
      return {v[7:0], v[15:8], v[23:16], v[31:24]};
   endfunction

endpackage

// File: rtl/irq_regdec_decode.sv
module irq_regdec_decode
   import irq_regdec_pkg::*;
#(
   parameter int unsigned NSRC = 40,
   parameter int unsigned AW   = 15,
   parameter int unsigned IW   = 6,
   parameter int unsigned WIW  = 1
) (
   input  logic [AW-1:0]  addr,
   input  logic [2:0]     size,
   output region_t        region,
   output logic [IW-1:0]  src_idx,
   output logic [WIW-1:0] word_idx,
   output logic           err
);
   localparam int unsigned NIRQ    = NSRC + 1;
   localparam int unsigned NWORDS  = (NIRQ + 31) / 32;
   localparam int unsigned ARR_SPAN = NSRC * 4;
   localparam int unsigned VEC_SPAN = NWORDS * 4;

   logic [31:0] off;

   always_comb begin
      off      = 32'(addr);
      region   = RG_NONE;
      src_idx  = '0;
      word_idx = '0;
      if (addr[1:0] == 2'b00 && size == 3'd4) begin
         if (off == OFS_DOM) region = RG_DOM;
         else if (off >= OFS_CFG && off < OFS_CFG + ARR_SPAN) begin
            region  = RG_CFG;
            src_idx = IW'((off - OFS_CFG) >> 2) + IW'(1);
         end
         else if (off >= OFS_TGT && off < OFS_TGT + ARR_SPAN) begin
            region  = RG_TGT;
            src_idx = IW'((off - OFS_TGT) >> 2) + IW'(1);
         end
         else if (off >= OFS_SETIP && off < OFS_SETIP + VEC_SPAN) begin
            region   = RG_SETIP;
            word_idx = WIW'((off - OFS_SETIP) >> 2);
         end
         else if (off >= OFS_INP && off < OFS_INP + VEC_SPAN) begin
            region   = RG_INP;
            word_idx = WIW'((off - OFS_INP) >> 2);
         end
         else if (off >= OFS_SETIE && off < OFS_SETIE + VEC_SPAN) begin
            region   = RG_SETIE;
            word_idx = WIW'((off - OFS_SETIE) >> 2);
         end
         else if (off >= OFS_CLRIE && off < OFS_CLRIE + VEC_SPAN) begin
            region   = RG_CLRIE;
            word_idx = WIW'((off - OFS_CLRIE) >> 2);
         end
         else if (off == OFS_SETIPN) region = RG_SETIPN;
         else if (off == OFS_CLRIPN) region = RG_CLRIPN;
         else if (off == OFS_SETIEN) region = RG_SETIEN;
         else if (off == OFS_CLRIEN) region = RG_CLRIEN;
         else if (off == OFS_NUM_LE) region = RG_NUM_LE;
         else if (off == OFS_NUM_BE) region = RG_NUM_BE;
         else if (off == OFS_GEN)    region = RG_GEN;
      end
      err = (region == RG_NONE);
   end

endmodule

// File: rtl/irq_regdec_mask.sv
module irq_regdec_mask
   import irq_regdec_pkg::*;
#(
   parameter int unsigned NIRQ = 41,
   parameter int unsigned WIW  = 1
) (
   input  region_t        region,
   input  logic [WIW-1:0] word_idx,
   input  logic [31:0]    wdata,
   output logic [NIRQ-1:0] mask
);
   logic [31:0] num;
   logic        is_num;
   logic        is_vec;

   always_comb begin
      num    = (region == RG_NUM_BE) ? swap_bytes(wdata) : wdata;
      is_num = region inside {RG_SETIPN, RG_CLRIPN, RG_SETIEN, RG_CLRIEN,
                              RG_NUM_LE, RG_NUM_BE};
      is_vec = region inside {RG_SETIP, RG_INP, RG_SETIE, RG_CLRIE};
   end

   for (genvar j = 0; j < NIRQ; j++) begin : g_bit
      localparam int unsigned WRD = j / 32;
      localparam int unsigned POS = j % 32;
      if (j == 0) begin : g_src0
         assign mask[j] = 1'b0;
      end else begin : g_src
         assign mask[j] = (is_num && num == 32'(j)) ||
                          (is_vec && word_idx == WIW'(WRD) && wdata[POS]);
      end
   end

endmodule

// File: rtl/irq_regdec_rdmux.sv
module irq_regdec_rdmux
   import irq_regdec_pkg::*;
#(
   parameter int unsigned NIRQ   = 41,
   parameter int unsigned NWORDS = 2,
   parameter int unsigned WIW    = 1
) (
   input  region_t         region,
   input  logic [WIW-1:0]  word_idx,
   input  logic            ie,
   input  logic [NIRQ-1:0] pend_bits,
   input  logic [NIRQ-1:0] enab_bits,
   input  logic [NIRQ-1:0] rin_bits,
   input  logic [31:0]     cfg_rdata,
   input  logic [31:0]     tgt_rdata,
   input  logic [31:0]     gen_rdata,
   output logic [31:0]     rdata
);
   localparam int unsigned VW = NWORDS * 32;

   logic [VW-1:0] pend_pad, enab_pad, rin_pad;

   always_comb begin
      pend_pad = '0;
      enab_pad = '0;
      rin_pad  = '0;
      pend_pad[NIRQ-1:0] = pend_bits & ~NIRQ'(1);
      enab_pad[NIRQ-1:0] = enab_bits & ~NIRQ'(1);
      rin_pad[NIRQ-1:0]  = rin_bits  & ~NIRQ'(1);
      unique case (region)
         RG_DOM:   rdata = DOM_FIXED | (32'(1) << DOM_DM_BIT) |
                           (32'(ie) << DOM_IE_BIT);
         RG_CFG:   rdata = cfg_rdata;
         RG_TGT:   rdata = tgt_rdata;
         RG_GEN:   rdata = gen_rdata;
         RG_SETIP: rdata = pend_pad[32*int'(word_idx) +: 32];
         RG_INP:   rdata = rin_pad[32*int'(word_idx) +: 32];
         RG_SETIE: rdata = enab_pad[32*int'(word_idx) +: 32];
         default:  rdata = '0;
      endcase
   end

endmodule

// File: rtl/irq_regdec.sv
module irq_regdec
   import irq_regdec_pkg::*;
#(
   parameter int unsigned NSRC = 40,
   parameter int unsigned AW   = 15,
   localparam int unsigned NIRQ   = NSRC + 1,
   localparam int unsigned NWORDS = (NIRQ + 31) / 32,
   localparam int unsigned IW     = $clog2(NIRQ),
   localparam int unsigned WIW    = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            acc_valid,
   input  logic            acc_write,
   input  logic [AW-1:0]   acc_addr,
   input  logic [2:0]      acc_size,
   input  logic [31:0]     acc_wdata,
   input  logic [NIRQ-1:0] pend_bits,
   input  logic [NIRQ-1:0] enab_bits,
   input  logic [NIRQ-1:0] rin_bits,
   input  logic [31:0]     cfg_rdata,
   input  logic [31:0]     tgt_rdata,
   input  logic [31:0]     gen_rdata,
   output logic [IW-1:0]   sel_src,
   output logic            cfg_we,
   output logic            tgt_we,
   output logic            gen_we,
   output logic [31:0]     wr_data,
   output logic [NIRQ-1:0] pend_set,
   output logic [NIRQ-1:0] pend_clr,
   output logic [NIRQ-1:0] enab_set,
   output logic [NIRQ-1:0] enab_clr,
   output logic            domain_ie,
   output logic            rsp_valid,
   output logic [31:0]     rsp_rdata,
   output logic            rsp_err
);

   if (NSRC < 1 || NSRC > 1023) begin : g_bad_nsrc
      $error("irq_regdec: NSRC must lie in 1..1023");
   end
   if (AW < 15) begin : g_bad_aw
      $error("irq_regdec: AW must be at least 15 to reach the target array");
   end

   region_t         region;
   logic [WIW-1:0]  word_idx;
   logic            dec_err;
   logic [NIRQ-1:0] mask;
   logic [31:0]     rd_word;
   logic            wr_ok;

   irq_regdec_decode #(.NSRC(NSRC), .AW(AW), .IW(IW), .WIW(WIW)) i_decode (
      .addr     (acc_addr),
      .size     (acc_size),
      .region   (region),
      .src_idx  (sel_src),
      .word_idx (word_idx),
      .err      (dec_err)
   );

   irq_regdec_mask #(.NIRQ(NIRQ), .WIW(WIW)) i_mask (
      .region   (region),
      .word_idx (word_idx),
      .wdata    (acc_wdata),
      .mask     (mask)
   );

   irq_regdec_rdmux #(.NIRQ(NIRQ), .NWORDS(NWORDS), .WIW(WIW)) i_rdmux (
      .region    (region),
      .word_idx  (word_idx),
      .ie        (domain_ie),
      .pend_bits (pend_bits),
      .enab_bits (enab_bits),
      .rin_bits  (rin_bits),
      .cfg_rdata (cfg_rdata),
      .tgt_rdata (tgt_rdata),
      .gen_rdata (gen_rdata),
      .rdata     (rd_word)
   );

   assign wr_ok   = acc_valid && acc_write && !dec_err;
   assign wr_data = acc_wdata;
   assign cfg_we  = wr_ok && region == RG_CFG;
   assign tgt_we  = wr_ok && region == RG_TGT;
   assign gen_we  = wr_ok && region == RG_GEN;

   always_comb begin
      pend_set = '0;
      pend_clr = '0;
      enab_set = '0;
      enab_clr = '0;
      if (wr_ok) begin
         unique case (region)
            RG_SETIP, RG_SETIPN, RG_NUM_LE, RG_NUM_BE: pend_set = mask;
            RG_INP, RG_CLRIPN:                         pend_clr = mask;
            RG_SETIE, RG_SETIEN:                       enab_set = mask;
            RG_CLRIE, RG_CLRIEN:                       enab_clr = mask;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         domain_ie <= 1'b0;
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
         rsp_err   <= 1'b0;
      end else begin
         if (wr_ok && region == RG_DOM) domain_ie <= acc_wdata[DOM_IE_BIT];
         rsp_valid <= acc_valid;
         rsp_err   <= acc_valid && dec_err;
         rsp_rdata <= (acc_valid && !acc_write && !dec_err) ? rd_word : '0;
      end
   end

   // R1: malformed accesses raise nothing now and report an error next
   p_bad_no_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && (acc_addr[1:0] != 2'b00 || acc_size != 3'd4) |->
         !(|{pend_set, pend_clr, enab_set, enab_clr, cfg_we, tgt_we, gen_we}));
   p_bad_err_r1: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && (acc_addr[1:0] != 2'b00 || acc_size != 3'd4) |=>
         rsp_err && rsp_rdata == 32'd0);

   // R3: the enable flag moves only on a domain configuration write
   p_ie_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_valid && acc_write && acc_size == 3'd4 && acc_addr == '0) |=>
         $stable(domain_ie));

   // R5: at most one class of strobe per cycle
   p_one_class_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({|pend_set, |pend_clr, |enab_set, |enab_clr,
                  cfg_we, tgt_we, gen_we}) <= 1);

   // R7: a by-number write touches at most one source
   p_num_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && acc_write &&
      region inside {RG_SETIPN, RG_CLRIPN, RG_SETIEN, RG_CLRIEN,
                     RG_NUM_LE, RG_NUM_BE} |->
         $onehot0(pend_set | pend_clr | enab_set | enab_clr));

   // R10: one reply per access, in the following cycle
   p_rsp_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> rsp_valid);
   p_rsp_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> !rsp_valid);

endmodule

// File: tb/test_irq_regdec.sv
`timescale 1ns/1ps
module test_irq_regdec;
   localparam int NSRC = 40;
   localparam int NIRQ = NSRC + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic acc_valid = 1'b0, acc_write = 1'b0;
   logic [14:0] acc_addr = '0;
   logic [2:0]  acc_size = 3'd4;
   logic [31:0] acc_wdata = '0;
   logic [NIRQ-1:0] pend_bits = '0, enab_bits = '0, rin_bits = '0;
   logic [31:0] cfg_rdata, tgt_rdata;
   logic [31:0] gen_rdata = 32'h5A5A_1234;
   logic [5:0]  sel_src;
   logic cfg_we, tgt_we, gen_we, domain_ie, rsp_valid, rsp_err;
   logic [31:0] wr_data, rsp_rdata;
   logic [NIRQ-1:0] pend_set, pend_clr, enab_set, enab_clr;

   int checks = 0;
   int fails = 0;
   logic exp_ie = 1'b0;

   logic e_err, e_cfg, e_tgt, e_gen;
   logic [31:0] e_rd;
   logic [5:0] e_sel;
   logic [NIRQ-1:0] e_ps, e_pc, e_es, e_ec;
   string e_req;

   always #10 clk = ~clk;

   assign cfg_rdata = 32'hC000_0000 | 32'(sel_src);
   assign tgt_rdata = 32'h7100_0000 | 32'(sel_src);

   irq_regdec #(.NSRC(NSRC), .AW(15)) i_irq_regdec (
      .clk, .rst_n, .acc_valid, .acc_write, .acc_addr, .acc_size, .acc_wdata,
      .pend_bits, .enab_bits, .rin_bits, .cfg_rdata, .tgt_rdata, .gen_rdata,
      .sel_src, .cfg_we, .tgt_we, .gen_we, .wr_data,
      .pend_set, .pend_clr, .enab_set, .enab_clr,
      .domain_ie, .rsp_valid, .rsp_rdata, .rsp_err
   );

   task automatic chk(input logic ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [NIRQ-1:0] vec_mask(input int w, input logic [31:0] d);
      logic [NIRQ-1:0] m = '0;
      for (int s = 1; s <= NSRC; s++)
         if (s / 32 == w && d[s % 32]) m[s] = 1'b1;
      return m;
   endfunction

   function automatic logic [NIRQ-1:0] num_mask(input logic [31:0] n);
      logic [NIRQ-1:0] m = '0;
      if (n >= 1 && n <= NSRC) m[n] = 1'b1;
      return m;
   endfunction

   function automatic logic [31:0] vec_word(input int w, input logic [NIRQ-1:0] v);
      logic [31:0] r = '0;
      for (int i = 0; i < 32; i++)
         if (32*w + i >= 1 && 32*w + i <= NSRC) r[i] = v[32*w + i];
      return r;
   endfunction

   // Reference model of one access, written from the requirements
   task automatic model(input int a, input int sz, input logic w, input logic [31:0] d);
      logic [31:0] sw;
      e_err = 1'b0; e_rd = '0; e_cfg = 0; e_tgt = 0; e_gen = 0; e_sel = '0;
      e_ps = '0; e_pc = '0; e_es = '0; e_ec = '0;
      sw = {d[7:0], d[15:8], d[23:16], d[31:24]};
      if (a % 4 != 0 || sz != 4) begin e_err = 1; e_req = "R1"; end
      else if (a == 0) begin
         e_req = "R3";
         e_rd = 32'h8000_0004 | (32'(exp_ie) << 8);
      end
      else if (a >= 4 && a < 4 + 4*NSRC) begin
         e_req = "R4"; e_sel = 6'((a - 4) / 4 + 1); e_cfg = w; e_rd = 32'hC000_0000 | 32'(e_sel);
      end
      else if (a >= 'h3004 && a < 'h3004 + 4*NSRC) begin
         e_req = "R4"; e_sel = 6'((a - 'h3004) / 4 + 1); e_tgt = w; e_rd = 32'h7100_0000 | 32'(e_sel);
      end
      else if (a >= 'h1C00 && a < 'h1C08) begin
         e_req = w ? "R5" : "R6"; e_ps = vec_mask((a - 'h1C00) / 4, d);
         e_rd = vec_word((a - 'h1C00) / 4, pend_bits);
      end
      else if (a >= 'h1D00 && a < 'h1D08) begin
         e_req = w ? "R5" : "R6"; e_pc = vec_mask((a - 'h1D00) / 4, d);
         e_rd = vec_word((a - 'h1D00) / 4, rin_bits);
      end
      else if (a >= 'h1E00 && a < 'h1E08) begin
         e_req = w ? "R5" : "R6"; e_es = vec_mask((a - 'h1E00) / 4, d);
         e_rd = vec_word((a - 'h1E00) / 4, enab_bits);
      end
      else if (a >= 'h1F00 && a < 'h1F08) begin
         e_req = w ? "R5" : "R6"; e_ec = vec_mask((a - 'h1F00) / 4, d);
      end
      else if (a == 'h1CDC || a == 'h2000) begin e_req = "R7"; e_ps = num_mask(d); end
      else if (a == 'h1DDC) begin e_req = "R7"; e_pc = num_mask(d); end
      else if (a == 'h1EDC) begin e_req = "R7"; e_es = num_mask(d); end
      else if (a == 'h1FDC) begin e_req = "R7"; e_ec = num_mask(d); end
      else if (a == 'h2004) begin e_req = "R8"; e_ps = num_mask(sw); end
      else if (a == 'h3000) begin e_req = "R9"; e_gen = w; e_rd = gen_rdata; end
      else begin e_err = 1; e_req = "R2"; end
      if (!w) begin e_ps = '0; e_pc = '0; e_es = '0; e_ec = '0; end
      if (w || e_err) e_rd = '0;
   endtask

   task automatic access(input int a, input int sz, input logic w, input logic [31:0] d);
      logic prev_ie;
      @(negedge clk);
      pend_bits = NIRQ'({$urandom(), $urandom()});
      enab_bits = NIRQ'({$urandom(), $urandom()});
      rin_bits  = NIRQ'({$urandom(), $urandom()});
      acc_valid = 1'b1; acc_write = w; acc_addr = 15'(a);
      acc_size = 3'(sz); acc_wdata = d;
      model(a, sz, w, d);
      #1;
      chk(pend_set == e_ps, e_req, "pend_set", 64'(pend_set), 64'(e_ps));
      chk(pend_clr == e_pc, e_req, "pend_clr", 64'(pend_clr), 64'(e_pc));
      chk(enab_set == e_es, e_req, "enab_set", 64'(enab_set), 64'(e_es));
      chk(enab_clr == e_ec, e_req, "enab_clr", 64'(enab_clr), 64'(e_ec));
      chk(cfg_we == e_cfg && tgt_we == e_tgt && gen_we == e_gen, e_req, "we",
          64'({cfg_we, tgt_we, gen_we}), 64'({e_cfg, e_tgt, e_gen}));
      if (e_cfg || e_tgt) chk(sel_src == e_sel, "R4", "sel_src", 64'(sel_src), 64'(e_sel));
      if (e_gen) chk(wr_data == d, "R9", "wr_data", 64'(wr_data), 64'(d));
      prev_ie = exp_ie;
      if (w && !e_err && a == 0) exp_ie = d[8];
      @(negedge clk);
      acc_valid = 1'b0;
      chk(rsp_valid == 1'b1, "R10", "rsp_valid", 64'(rsp_valid), 64'd1);
      chk(rsp_err == e_err, e_err ? e_req : "R2", "rsp_err", 64'(rsp_err), 64'(e_err));
      chk(rsp_rdata == e_rd, e_req, "rsp_rdata", 64'(rsp_rdata), 64'(e_rd));
      chk(domain_ie == exp_ie, (prev_ie == exp_ie) ? "R1" : "R3", "domain_ie",
          64'(domain_ie), 64'(exp_ie));
   endtask

   function automatic int pick_addr();
      int r = int'($urandom_range(0, 13));
      int b;
      case (r)
         0: b = 0;
         1: b = 4 + 4*int'($urandom_range(0, NSRC));
         2: b = 'h3004 + 4*int'($urandom_range(0, NSRC));
         3: b = 'h1C00 + 4*int'($urandom_range(0, 2));
         4: b = 'h1D00 + 4*int'($urandom_range(0, 2));
         5: b = 'h1E00 + 4*int'($urandom_range(0, 2));
         6: b = 'h1F00 + 4*int'($urandom_range(0, 2));
         7: b = 'h1CDC;
         8: b = 'h1DDC;
         9: b = 'h1EDC;
         10: b = 'h1FDC;
         11: b = 'h2000 + 4*int'($urandom_range(0, 1));
         12: b = 'h3000;
         default: b = int'($urandom_range(0, 'h3FFF)) & ~3;
      endcase
      if ($urandom_range(0, 9) == 0) b = b + int'($urandom_range(1, 3));
      return b;
   endfunction

   initial begin
      #(200000 * 20);
      chk(1'b0, "R10", "watchdog expired", 64'd0, 64'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd1357));
      repeat (3) @(negedge clk);
      chk(rsp_valid == 1'b0, "R10", "reset rsp_valid", 64'(rsp_valid), 64'd0);
      chk(domain_ie == 1'b0, "R3", "reset domain_ie", 64'(domain_ie), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R10", "idle rsp_valid", 64'(rsp_valid), 64'd0);

      // Directed corner cases
      access(0, 4, 0, 0);                        // R3 read after reset
      access(0, 4, 1, 32'hFFFF_FEFF);            // R3 bit 8 low leaves IE clear
      access(0, 4, 1, 32'h0000_0100);            // R3 set IE
      access(0, 4, 0, 0);
      access(2, 4, 1, 32'h0000_0000);            // R1 misaligned
      access(0, 2, 1, 32'h0000_0000);            // R1 short access
      access('h1C00, 1, 1, 32'hFFFF_FFFF);       // R1 byte write to vector
      access(4, 4, 1, 32'h1234_5678);            // R4 first source
      access(4 + 4*(NSRC-1), 4, 0, 0);           // R4 last source
      access(4 + 4*NSRC, 4, 0, 0);               // R2 one past end
      access('h3004 + 4*(NSRC-1), 4, 1, 32'h5);  // R4 last target
      access('h1C00, 4, 1, 32'hFFFF_FFFF);       // R5 source 0 dropped
      access('h1C04, 4, 1, 32'hFFFF_FFFF);       // R5 bits past NSRC dropped
      access('h1C08, 4, 1, 32'hFFFF_FFFF);       // R2 past last word
      access('h1D04, 4, 0, 0);                   // R6 rectified inputs
      access('h1F00, 4, 0, 0);                   // R6 clear-enable reads 0
      access('h1CDC, 4, 1, 32'd0);               // R7 zero ignored
      access('h1EDC, 4, 1, 32'(NSRC));           // R7 last source
      access('h1FDC, 4, 1, 32'(NSRC + 1));       // R7 past end ignored
      access('h2000, 4, 1, 32'd1);               // R7 little-endian
      access('h2004, 4, 1, 32'h0500_0000);       // R8 byte swapped 5
      access('h2004, 4, 1, 32'h0000_0005);       // R8 unswapped huge number
      access('h2004, 4, 0, 0);                   // R8 reads 0
      access('h3000, 4, 1, 32'hDEAD_BEEF);       // R9
      access('h3000, 4, 0, 0);                   // R9 readback

      // Constrained random accesses
      for (int k = 0; k < 600; k++) begin
         int a = pick_addr();
         int sz = ($urandom_range(0, 11) == 0) ? int'($urandom_range(1, 3)) : 4;
         logic w = 1'($urandom());
         logic [31:0] d = $urandom();
         if (a == 'h1CDC || a == 'h1DDC || a == 'h1EDC || a == 'h1FDC || a == 'h2000)
            d = 32'($urandom_range(0, NSRC + 3));
         else if (a == 'h2004 && $urandom_range(0, 3) != 0)
            d = {8'($urandom_range(0, NSRC + 3)), 24'd0};
         access(a, sz, w, d);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule